// File: doc/BRIEF.md
# Transmit Gap and Priority Arbiter

This block merges two byte streams onto a single transmit stream. One input carries locally generated time-synchronisation messages; the other carries frames from the host DMA path. Every stream, input or output, uses a valid/ready handshake with a last-byte marker. Ownership of the output changes only at a frame boundary. Once a source has been granted the output, it keeps the output until the output accepts its last byte.

After each frame the arbiter holds the output idle for a programmable number of transmit clock cycles, so the next frame starts no sooner than that. A value of 0 lets frames run back to back. A single configuration bit sets which source wins when both are waiting at a free boundary: timing messages by default, or DMA traffic when the bit is set. The gap value is sampled only when a frame ends. A change to it therefore applies from the next frame boundary. The usual setting is 40 cycles.

The forward and backward paths pass straight through to the current owner, with no added latency. The block's only state is the owner, a frame-in-progress flag and the gap counter.

Top module: `tx_gap_arbiter`

## Requirements
- R1: After reset, with no input valid, out_valid, sync_ready and dma_ready are all 0. A frame offered with gap_cycles at 0 may appear on the output in the first cycle after reset.
- R2: With gap_cycles = n > 0, out_valid stays 0 for at least n cycles after the cycle in which the output accepts a last byte. When a frame is pending, it starts exactly in cycle n+1.
- R3: With gap_cycles = 0, a pending frame's first byte is presented in the cycle right after the previous last byte was accepted.
- R4: When dma_first = 0 and both sources are valid at a free boundary, the timing-message source is granted.
- R5: When dma_first = 1 and both sources are valid at a free boundary, the DMA source is granted.
- R6: A frame in progress is never interrupted. No byte of the other source appears on the output until the owner's last byte has been accepted, even when the other source has priority.
- R7: gap_cycles is sampled only in the cycle the output accepts a last byte. A change made while a gap is counting does not alter that gap.
- R8: out_data and out_last equal the owner's data and last. out_ready is returned only to the owner's ready, and the other source's ready is 0.
- R9: Once a first byte is offered and out_ready is 0, the grant is held. A higher-priority source arriving later does not replace the offered byte.
- R10: The 7-bit gap setting works at its usual value of 40 (0x28): exactly 40 idle cycles between back-to-back frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous active-high reset |
| gap_cycles | input | GAP_W (7) | Idle cycles to insert after each frame |
| dma_first | input | 1 | 0: timing messages win ties, 1: DMA frames win ties |
| sync_valid | input | 1 | Timing-message byte valid |
| sync_data | input | DATA_W (8) | Timing-message byte |
| sync_last | input | 1 | Last byte of timing message |
| sync_ready | output | 1 | Timing-message byte accepted |
| dma_valid | input | 1 | DMA byte valid |
| dma_data | input | DATA_W (8) | DMA byte |
| dma_last | input | 1 | Last byte of DMA frame |
| dma_ready | output | 1 | DMA byte accepted |
| out_valid | output | 1 | Output byte valid |
| out_data | output | DATA_W (8) | Output byte |
| out_last | output | 1 | Last byte of output frame |
| out_ready | input | 1 | Downstream accepts output byte |

## Verification
If the gap counter holds a wrong value, out_valid rises too early or too late after a frame ends. The count of idle cycles between two measured frames then differs from the setting, so the error appears at the very next boundary. A wrong owner or a lost frame-in-progress flag shows within one cycle as a byte from the wrong source, or as a ready returned to a source that is not being forwarded. The reference model compares every port on every clock, so such errors are reported in the cycle they first appear.

// File: rtl/tx_arb_pkg.sv
package tx_arb_pkg;
  typedef enum logic {
    SRC_SYNC = 1'b0,
    SRC_DMA  = 1'b1
  } src_e;
endpackage

// File: rtl/tx_gap_timer.sv
module tx_gap_timer #(
  parameter int GAP_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [GAP_W-1:0] load_val,
  output logic             gap_idle
);
  logic [GAP_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign gap_idle = (cnt == '0);

  // R7: the value captured at a frame end is the value present on that cycle
  assert_gap_load_R7: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(load_val)));

  // R2: a running gap counts down by exactly one per cycle
  assert_gap_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/tx_src_picker.sv
module tx_src_picker (
  input  logic                 sync_req,
  input  logic                 dma_req,
  input  logic                 dma_first,
  output logic                 any_req,
  output tx_arb_pkg::src_e     grant_src
);
  import tx_arb_pkg::*;

  always_comb begin
    any_req = sync_req | dma_req;
    if (sync_req && dma_req) begin
      grant_src = dma_first ? SRC_DMA : SRC_SYNC;
    end else if (dma_req) begin
      grant_src = SRC_DMA;
    end else begin
      grant_src = SRC_SYNC;
    end
  end
endmodule

// File: rtl/tx_frame_owner.sv
module tx_frame_owner (
  input  logic             clk,
  input  logic             rst,
  input  logic             gap_idle,
  input  logic             any_req,
  input  tx_arb_pkg::src_e grant_src,
  input  logic             beat_valid,
  input  logic             beat_fire,
  input  logic             beat_last,
  output logic             in_frame,
  output tx_arb_pkg::src_e cur_src,
  output logic             path_en
);
  import tx_arb_pkg::*;

  src_e owner_q;
  logic free;

  assign free    = !in_frame && gap_idle;
  assign cur_src = in_frame ? owner_q : grant_src;
  assign path_en = in_frame || (free && any_req);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame <= 1'b0;
      owner_q  <= SRC_SYNC;
    end else if (path_en && beat_valid) begin
      if (beat_fire && beat_last) begin
        in_frame <= 1'b0;
      end else begin
        in_frame <= 1'b1;
        owner_q  <= cur_src;
      end
    end
  end

  // R6: no change of owner until the last byte is accepted
  assert_hold_owner_R6: assert property (@(posedge clk) disable iff (rst)
    (in_frame && !(beat_fire && beat_last)) |=> (in_frame && cur_src == $past(cur_src)));

  // R9: an offered but stalled byte locks the grant
  assert_stall_lock_R9: assert property (@(posedge clk) disable iff (rst)
    (path_en && beat_valid && !beat_fire) |=> (in_frame && cur_src == $past(cur_src)));
endmodule

// File: rtl/tx_gap_arbiter.sv
module tx_gap_arbiter #(
  parameter int DATA_W = 8,
  parameter int GAP_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [GAP_W-1:0]  gap_cycles,
  input  logic              dma_first,
  input  logic              sync_valid,
  input  logic [DATA_W-1:0] sync_data,
  input  logic              sync_last,
  output logic              sync_ready,
  input  logic              dma_valid,
  input  logic [DATA_W-1:0] dma_data,
  input  logic              dma_last,
  output logic              dma_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  input  logic              out_ready
);
  import tx_arb_pkg::*;

  logic gap_idle, any_req, in_frame, path_en, fire, beat_valid, beat_last;
  src_e grant_src, cur_src;

  tx_src_picker u_pick (
    .sync_req (sync_valid),
    .dma_req  (dma_valid),
    .dma_first(dma_first),
    .any_req  (any_req),
    .grant_src(grant_src)
  );

  tx_frame_owner u_own (
    .clk       (clk),
    .rst       (rst),
    .gap_idle  (gap_idle),
    .any_req   (any_req),
    .grant_src (grant_src),
    .beat_valid(beat_valid),
    .beat_fire (fire),
    .beat_last (beat_last),
    .in_frame  (in_frame),
    .cur_src   (cur_src),
    .path_en   (path_en)
  );

  tx_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk     (clk),
    .rst     (rst),
    .load    (fire && beat_last),
    .load_val(gap_cycles),
    .gap_idle(gap_idle)
  );

  always_comb begin
    if (cur_src == SRC_DMA) begin
      beat_valid = dma_valid;
      beat_last  = dma_last;
      out_data   = dma_data;
    end else begin
      beat_valid = sync_valid;
      beat_last  = sync_last;
      out_data   = sync_data;
    end
    out_valid  = path_en && beat_valid;
    out_last   = beat_last;
    fire       = out_valid && out_ready;
    sync_ready = path_en && (cur_src == SRC_SYNC) && out_ready;
    dma_ready  = path_en && (cur_src == SRC_DMA) && out_ready;
  end

  // R2: a frame may only open once the gap has run out
  assert_start_after_gap_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !in_frame) |-> gap_idle);

  // R4: timing messages win a tie when dma_first is 0
  assert_sync_wins_R4: assert property (@(posedge clk) disable iff (rst)
    (!in_frame && gap_idle && sync_valid && dma_valid && !dma_first) |-> (!dma_ready && out_data == sync_data));

  // R5: DMA wins a tie when dma_first is 1
  assert_dma_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (!in_frame && gap_idle && sync_valid && dma_valid && dma_first) |-> (!sync_ready && out_data == dma_data));

  // R8: at most one source sees ready
  assert_one_ready_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sync_ready, dma_ready}));
endmodule

// File: tb/tx_gap_arbiter_test.sv
`timescale 1ns/1ps
module tx_gap_arbiter_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] gap_cycles = '0;
  logic       dma_first = 1'b0;
  logic       sync_valid = 1'b0, sync_last = 1'b0, dma_valid = 1'b0, dma_last = 1'b0;
  logic [7:0] sync_data = '0, dma_data = '0;
  logic       sync_ready, dma_ready, out_valid, out_last;
  logic [7:0] out_data;
  logic       out_ready = 1'b1;

  always #2 clk = ~clk;

  tx_gap_arbiter uut (
    .clk(clk), .rst(rst), .gap_cycles(gap_cycles), .dma_first(dma_first),
    .sync_valid(sync_valid), .sync_data(sync_data), .sync_last(sync_last), .sync_ready(sync_ready),
    .dma_valid(dma_valid), .dma_data(dma_data), .dma_last(dma_last), .dma_ready(dma_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready)
  );

  int vectors = 0, errors = 0, cyc = 0;
  bit finished = 0;
  bit rand_ready = 0;
  logic [7:0] sq[$], dq[$];
  bit sl[$], dl[$];
  // reference state
  bit m_act = 0; int m_own = 0; int m_gap = 0;
  // frame log: byte bit 7 tells the source (0 timing, 1 DMA)
  int fstart[64], fend[64], fsrc[64], flen[64];
  int nf = 0; bit fopen = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push_sync(int n, int base);
    for (int i = 0; i < n; i++) begin sq.push_back(8'(base + i) & 8'h7f); sl.push_back(i == n - 1); end
  endtask
  task automatic push_dma(int n, int base);
    for (int i = 0; i < n; i++) begin dq.push_back(8'(base + i) | 8'h80); dl.push_back(i == n - 1); end
  endtask

  task automatic step();
    bit sv, dv, free, en, ev, er, el, erdy;
    int pk;
    logic [7:0] ed;
    @(negedge clk);
    sv = sq.size() > 0; dv = dq.size() > 0;
    sync_valid = sv; sync_data = sv ? sq[0] : 8'h00; sync_last = sv ? sl[0] : 1'b0;
    dma_valid  = dv; dma_data  = dv ? dq[0] : 8'h00; dma_last  = dv ? dl[0] : 1'b0;
    if (rand_ready) out_ready = ($urandom % 4) != 0;
    #1;
    erdy = out_ready;
    free = !m_act && m_gap == 0;
    pk = m_act ? m_own : ((sv && dv) ? int'(dma_first) : (dv ? 1 : 0));
    en = m_act || (free && (sv || dv));
    ev = en && (pk == 1 ? dv : sv);
    ed = pk == 1 ? dma_data : sync_data;
    el = pk == 1 ? dma_last : sync_last;
    chk(out_valid === ev, "R8 out_valid", out_valid, ev);
    chk(sync_ready === (en && pk == 0 && erdy), "R8 sync_ready", sync_ready, en && pk == 0 && erdy);
    chk(dma_ready === (en && pk == 1 && erdy), "R8 dma_ready", dma_ready, en && pk == 1 && erdy);
    if (ev) begin
      chk(out_data === ed, "R8 out_data", out_data, ed);
      chk(out_last === el, "R8 out_last", out_last, el);
    end
    @(posedge clk);
    er = ev && erdy;
    if (er) begin
      if (!fopen) begin fstart[nf] = cyc; fsrc[nf] = ed[7]; flen[nf] = 0; fopen = 1; end
      flen[nf]++;
      if (el) begin fend[nf] = cyc; fopen = 0; if (nf < 63) nf++; end
      if (pk == 1) begin void'(dq.pop_front()); void'(dl.pop_front()); end
      else begin void'(sq.pop_front()); void'(sl.pop_front()); end
    end
    if (ev) begin
      if (er && el) m_act = 0; else begin m_act = 1; m_own = pk; end
    end
    if (er && el) m_gap = gap_cycles; else if (m_gap > 0) m_gap--;
    cyc++;
    #1;
  endtask

  task automatic drain(int extra);
    while (sq.size() > 0 || dq.size() > 0) step();
    repeat (extra) step();
  endtask

  function automatic int idle_between(int j);
    return fstart[j] - fend[j-1] - 1;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: quiet after reset
    #1;
    chk(out_valid === 1'b0, "R1 out_valid", out_valid, 0);
    chk(sync_ready === 1'b0 && dma_ready === 1'b0, "R1 readies", sync_ready | dma_ready, 0);
    push_sync(1, 5);
    step();
    chk(nf == 1, "R1 immediate frame", nf, 1);

    // R2 / R4: timing wins the tie, gap of 5
    drain(3); nf = 0;
    gap_cycles = 7'd5; dma_first = 0;
    push_sync(3, 16); push_dma(2, 16);
    drain(8);
    chk(nf == 2 && fsrc[0] == 0, "R4 timing first", fsrc[0], 0);
    chk(idle_between(1) == 5, "R2 gap 5", idle_between(1), 5);

    // R3: zero gap, back to back
    nf = 0; gap_cycles = 7'd0;
    push_sync(2, 32); push_sync(1, 40);
    drain(2);
    chk(idle_between(1) == 0, "R3 no gap", idle_between(1), 0);

    // R5: DMA wins the tie
    nf = 0; gap_cycles = 7'd3; dma_first = 1;
    push_sync(2, 48); push_dma(2, 48);
    drain(5);
    chk(fsrc[0] == 1, "R5 DMA first", fsrc[0], 1);
    chk(idle_between(1) == 3, "R2 gap 3", idle_between(1), 3);

    // R6: no preemption, with a stalling downstream
    nf = 0; gap_cycles = 7'd2; dma_first = 0; rand_ready = 1;
    push_dma(6, 64);
    repeat (3) step();
    push_sync(2, 64);
    drain(4);
    rand_ready = 0; out_ready = 1;
    chk(fsrc[0] == 1 && flen[0] == 6, "R6 DMA frame whole", flen[0], 6);
    chk(fsrc[1] == 0 && idle_between(1) >= 2, "R6 timing after", idle_between(1), 2);

    // R7: mid-gap change does not alter the running gap
    nf = 0; gap_cycles = 7'd12;
    push_sync(2, 80); push_dma(2, 80);
    while (nf < 1) step();
    repeat (3) step();
    gap_cycles = 7'd1;
    drain(3);
    chk(idle_between(1) == 12, "R7 gap held at 12", idle_between(1), 12);
    nf = 0;
    push_sync(1, 90); push_sync(1, 91);
    drain(3);
    chk(idle_between(1) == 1, "R7 new gap 1", idle_between(1), 1);

    // R9: stalled first byte keeps its grant
    nf = 0; gap_cycles = 7'd0; dma_first = 0; out_ready = 0;
    push_sync(2, 96);
    step();
    dma_first = 1; push_dma(2, 96);
    step(); step();
    #1;
    chk(out_valid === 1'b1 && out_data === 8'd96, "R9 stalled byte kept", out_data, 96);
    chk(dma_ready === 1'b0, "R9 DMA not granted", dma_ready, 0);
    out_ready = 1;
    drain(2);
    chk(fsrc[0] == 0, "R9 timing sent first", fsrc[0], 0);

    // R10: usual setting of 40
    nf = 0; gap_cycles = 7'h28;
    push_sync(2, 100); push_sync(3, 110);
    drain(42);
    chk(idle_between(1) == 40, "R10 gap 40", idle_between(1), 40);

    // mixed traffic: R8 model compare every cycle
    rand_ready = 1;
    for (int k = 0; k < 60; k++) begin
      gap_cycles = 7'($urandom % 6);
      dma_first = $urandom % 2;
      if ($urandom % 2) push_sync(1 + $urandom % 4, k);
      if ($urandom % 2) push_dma(1 + $urandom % 5, k);
      repeat (1 + $urandom % 6) step();
    end
    drain(10);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    #(150000 * 4);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule